// File: doc/BRIEF.md
# Coherent Byte-Wise Counter Snapshot Reader

A free-running event counter, clocked by a slow and unrelated counter clock, is read by a byte-wide processor bus. The read takes several separate bus cycles, one byte per cycle. The block keeps a bank of byte-wide capture registers. These registers reload from the counter on each rising edge of a gated copy of the counter clock. Each register is selected for reading by its own active-low enable line.

When any enable is pulled low, the block withdraws its run request and stops the gated clock. It stops the clock only at a pulse boundary: a pulse that has already started runs to its end, and no pulse ever starts partway through. The captured value therefore stays frozen and consistent for as long as at least one enable is held low. When all enables return high, the gated clock follows the counter clock again, also on whole pulses only.

All logic runs on a system clock that is faster than the counter clock. The counter clock and the enable lines each pass through two-flop synchronizers. The counter advances on each synchronized rising edge of the counter clock.

Top module: `snapshot_reader`

## Requirements
- R1: The internal counter is NUM_BYTES*BYTE_W bits wide. It increases by one for every rising edge of `cnt_clk`, whether gated or not, and wraps modulo 2^(NUM_BYTES*BYTE_W).
- R2: Capture register k holds counter bits [k*BYTE_W +: BYTE_W]. Driving `rd_en_n[k]` low makes that byte appear on `rd_data` with `rd_valid` high, on the third rising `clk` edge after the enable changes.
- R3: The capture registers change only on a rising edge of the gated clock. They then load the counter value that includes the edge just seen.
- R4: With every enable high, `rd_valid` is 0 and `rd_data` is all zeros.
- R5: While any enable is low, no new gated pulse starts, so the captured value cannot change.
- R6: Every high period of `gate_clk_o` spans exactly one whole high period of the synchronized counter clock. A pulse is never cut short by a read and never begins late.
- R7: Once all enables are high again, `gate_clk_o` resumes pulsing with `cnt_clk`, starting from the next whole pulse.
- R8: All bytes read while at least one enable stays low throughout come from a single snapshot. That snapshot equals the number of counter-clock rising edges up to the freeze.
- R9: When several enables are low together, the byte with the lowest index is driven.
- R10: After reset the counter, the capture registers, `rd_valid`, `rd_data` and `gate_clk_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the counter clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clk | input | 1 | Counter clock, asynchronous to `clk` |
| rd_en_n | input | NUM_BYTES | Active-low read select, one line per capture byte |
| rd_valid | output | 1 | High when some enable is low and `rd_data` carries a byte |
| rd_data | output | BYTE_W | Selected capture byte, zero when nothing is selected |
| gate_clk_o | output | 1 | Gated counter clock, as seen in the system clock domain |

## Verification
The whole-pulse assertions assume that `cnt_clk` stays at each level for several system clock cycles. Each level must last longer than the synchronizer delay, so the synchronized copy never skips a pulse. The capture assertions assume that the enables are stable across the two synchronizer stages and do not toggle faster than that.

The stimulus meets both assumptions by design. It drives a counter clock with a 16-cycle period and 8-cycle halves. It changes enables only on falling `clk` edges, and only at chosen phases of the counter clock: in the middle of a pulse, in the middle of a gap, and at the start of a pulse. Switching from one byte to the next always keeps at least one line low.

// File: rtl/snapro_pkg.sv
package snapro_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;
endpackage

// File: rtl/snapro_sync.sv
module snapro_sync #(
  parameter int             WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/snapro_counter.sv
module snapro_counter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/snapro_gate.sv
module snapro_gate
  import snapro_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ck_s,
  output logic tick,
  output logic gclk,
  output logic cap_en
);
  logic  ck_d;
  gate_e mode_q;
  logic  gclk_q;
  logic  gclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_d   <= 1'b0;
      mode_q <= GATE_SHUT;
      gclk_q <= 1'b0;
      gclk_d <= 1'b0;
    end else begin
      ck_d <= ck_s;
      // the gate decision is taken only in the gap between pulses
      if (!ck_s && !gclk_q)
        mode_q <= run ? GATE_OPEN : GATE_SHUT;
      gclk_q <= (mode_q == GATE_OPEN) && ck_s;
      gclk_d <= gclk_q;
    end
  end

  assign tick   = ck_s & ~ck_d;
  assign gclk   = gclk_q;
  assign cap_en = gclk_q & ~gclk_d;
endmodule

// File: rtl/snapro_bank.sv
module snapro_bank #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int TOTAL_W  = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_en,
  input  logic [TOTAL_W-1:0]   value,
  input  logic [NUM_BYTES-1:0] en_s,
  output logic [TOTAL_W-1:0]   snap,
  output logic                 rd_valid,
  output logic [BYTE_W-1:0]    rd_data
);
  logic [BYTE_W-1:0] byte_q [NUM_BYTES];
  logic [BYTE_W-1:0] sel_data;
  logic              hit;
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)         byte_q[k] <= '0;
      else if (cap_en) byte_q[k] <= value[k*BYTE_W +: BYTE_W];
    end
    assign snap[k*BYTE_W +: BYTE_W] = byte_q[k];
  end

  // lowest selected index wins: scan from the top down
  always_comb begin
    sel_data = '0;
    for (int k = NUM_BYTES - 1; k >= 0; k--) begin
      if (!en_s[k]) sel_data = byte_q[k];
    end
    hit = ~&en_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= hit;
      data_q  <= hit ? sel_data : '0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;
endmodule

// File: rtl/snapshot_reader.sv
module snapshot_reader #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cnt_clk,
  input  logic [NUM_BYTES-1:0] rd_en_n,
  output logic                 rd_valid,
  output logic [BYTE_W-1:0]    rd_data,
  output logic                 gate_clk_o
);
  localparam int TOTAL_W = BYTE_W * NUM_BYTES;

  logic                 ck_s;
  logic [NUM_BYTES-1:0] en_s;
  logic                 run_s;
  logic                 tick;
  logic                 gclk;
  logic                 cap_en;
  logic [TOTAL_W-1:0]   count_q;
  logic [TOTAL_W-1:0]   snap_q;

  snapro_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_ck_sync (
    .clk(clk), .rst(rst), .d(cnt_clk), .q(ck_s)
  );

  snapro_sync #(.WIDTH(NUM_BYTES), .RST_VAL({NUM_BYTES{1'b1}})) u_en_sync (
    .clk(clk), .rst(rst), .d(rd_en_n), .q(en_s)
  );

  assign run_s = &en_s;

  snapro_gate u_gate (
    .clk(clk), .rst(rst), .run(run_s), .ck_s(ck_s),
    .tick(tick), .gclk(gclk), .cap_en(cap_en)
  );

  snapro_counter #(.WIDTH(TOTAL_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count(count_q)
  );

  snapro_bank #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_bank (
    .clk(clk), .rst(rst), .cap_en(cap_en), .value(count_q), .en_s(en_s),
    .snap(snap_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign gate_clk_o = gclk;
endmodule

// File: rtl/snapshot_reader_chk.sv
module snapshot_reader_chk #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int TOTAL_W  = BYTE_W * NUM_BYTES
) (
  input logic               clk,
  input logic               rst,
  input logic               ck_s,
  input logic               run_s,
  input logic               gclk,
  input logic [TOTAL_W-1:0] count_q,
  input logic [TOTAL_W-1:0] snap_q,
  input logic               rd_valid,
  input logic [BYTE_W-1:0]  rd_data
);
  // R1: the counter only ever steps by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 1'b1));

  // R3: with the gated clock low, the snapshot holds on the next edge
  a_r3_capture_gated: assert property (@(posedge clk) disable iff (rst)
    !gclk |=> (snap_q == $past(snap_q)));

  // R4: no selection means an empty bus
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R5: with run withdrawn during a gap, no pulse begins
  a_r5_no_new_pulse: assert property (@(posedge clk) disable iff (rst)
    (!run_s && !gclk && !ck_s) |=> !gclk);

  // R6: a gated pulse starts only on the first high cycle of the counter clock
  a_r6_whole_start: assert property (@(posedge clk) disable iff (rst)
    $rose(gclk) |-> ($past(ck_s) && !$past(ck_s, 2)));

  // R6: a gated pulse ends only when the counter clock has gone low
  a_r6_whole_end: assert property (@(posedge clk) disable iff (rst)
    $fell(gclk) |-> !$past(ck_s));
endmodule

bind snapshot_reader snapshot_reader_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rst(rst), .ck_s(ck_s), .run_s(run_s), .gclk(gclk),
  .count_q(count_q), .snap_q(snap_q), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sim_snapshot_reader.sv
`timescale 1ns/1ps
module sim_snapshot_reader;
  localparam int BW   = 4;
  localparam int NB   = 3;
  localparam int W    = BW * NB;
  localparam int HALF = 8;
  localparam int PER  = 2 * HALF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_clk = 1'b0;
  logic [NB-1:0] en_n = '1;
  logic          rd_valid;
  logic [BW-1:0] rd_data;
  logic          gate_clk_o;

  int          n_tests = 0;
  int          n_fail  = 0;
  int          ph      = PER - 1;
  int unsigned edges   = 0;
  logic        gen_on  = 1'b0;
  logic        frozen  = 1'b0;
  int          frozen_rises = 0;
  int          gate_rises   = 0;
  int          hi_len = 0;
  logic        prev_g = 1'b0;
  logic        done   = 1'b0;

  always #2.5 clk = ~clk;

  snapshot_reader #(.BYTE_W(BW), .NUM_BYTES(NB)) u0 (
    .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .rd_en_n(en_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .gate_clk_o(gate_clk_o)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counter clock generator: rises when the phase wraps to 0
  always @(negedge clk) begin
    if (rst || !gen_on) begin
      ph      <= PER - 1;
      cnt_clk <= 1'b0;
    end else begin
      ph      <= (ph + 1) % PER;
      cnt_clk <= ((ph + 1) % PER) < HALF;
      if (((ph + 1) % PER) == 0) edges <= edges + 1;
    end
  end

  // gated clock monitor: pulse width and pulses while frozen
  always @(negedge clk) begin
    if (!rst) begin
      if (gate_clk_o) hi_len++;
      if (!gate_clk_o && prev_g) begin
        chk(hi_len == HALF, "R6 gated pulse width", hi_len, HALF);
        hi_len = 0;
      end
      if (gate_clk_o && !prev_g) begin
        gate_rises++;
        if (frozen) frozen_rises++;
      end
      prev_g = gate_clk_o;
    end
  end

  task automatic read_byte(input int k, input logic [NB-1:0] pat, input logic [W-1:0] snap, input string tag);
    @(negedge clk) en_n = pat;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rd_valid == 1'b1, tag, rd_valid, 1);
    chk(rd_data == snap[k*BW +: BW], tag, rd_data, snap[k*BW +: BW]);
  endtask

  task automatic freeze(input int at_ph, input int hold_per, input int rel_ph, input logic prio);
    logic [W-1:0] refv;
    logic [W-1:0] got;
    int           r0;
    do @(posedge clk); while (ph != at_ph);
    @(negedge clk);
    en_n   = 3'b110;
    frozen = 1'b1;
    refv   = W'(edges);
    frozen_rises = 0;
    repeat (hold_per * PER) @(negedge clk);
    got = '0;
    for (int k = 0; k < NB; k++) begin
      read_byte(k, ~(NB'(1) << k), refv, "R8 byte of frozen snapshot");
      got[k*BW +: BW] = rd_data;
    end
    chk(got == refv, "R1 snapshot equals edge count modulo width", got, refv);
    if (prio) begin
      read_byte(0, 3'b000, refv, "R9 all low selects byte 0");
      read_byte(1, 3'b001, refv, "R9 bytes 1,2 low selects byte 1");
      read_byte(2, 3'b011, refv, "R9 byte 2 alone");
    end
    chk(frozen_rises == 0, "R5 no gated pulse while frozen", frozen_rises, 0);
    do @(posedge clk); while (ph != rel_ph);
    @(negedge clk);
    en_n   = '1;
    frozen = 1'b0;
    r0 = gate_rises;
    repeat (3 * PER) @(negedge clk);
    chk((gate_rises - r0) >= 2, "R7 gated clock resumes", gate_rises - r0, 2);
    chk(rd_valid == 1'b0 && rd_data == '0, "R4 idle bus after release", rd_data, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 rd_valid after reset", rd_valid, 0);
    chk(rd_data == '0, "R10 rd_data after reset", rd_data, 0);
    chk(gate_clk_o == 1'b0, "R10 gate low after reset", gate_clk_o, 0);
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == '0, "R4 idle bus", rd_data, 0);
    // latency from the enable edge, with the counter clock still idle
    en_n = 3'b110;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R2 not valid after two edges", rd_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R2 valid on third edge", rd_valid, 1);
    chk(rd_data == '0, "R10 snapshot zero after reset", rd_data, 0);
    read_byte(1, 3'b101, '0, "R10 byte 1 zero after reset");
    read_byte(2, 3'b011, '0, "R10 byte 2 zero after reset");
    @(negedge clk) en_n = '1;
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == '0, "R4 idle bus after read", rd_data, 0);
    @(posedge clk);
    #1 gen_on = 1'b1;
    repeat (3 * PER) @(negedge clk);
    // sweep freeze phase, hold time and release phase; passes a full wrap
    for (int i = 0; i < 45; i++) begin
      repeat ((88 + (i % 7) * 3) * PER) @(negedge clk);
      freeze(((i % 2) != 0) ? 10 : 6, 1 + (i % 3), (i % 4) * 4 + 1, (i % 9) == 4);
    end
    chk(edges > (1 << W), "R1 sweep crossed counter wrap", edges, 1 << W);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule